// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

This block is one output compare channel. It follows one of two shared timer counts and drives a single output pin from it. A 16-bit control word picks the behaviour. The channel can set, clear or toggle the pin on a compare match, emit single or repeating pulses bounded by two compare values, or produce edge-aligned PWM with an optional active-low fault input that shuts the pin off.

The surrounding system supplies the two timer counts with their period strobes, the primary and secondary compare values, an idle request and the fault line. The block returns the pin level and a one-clock event strobe for an interrupt controller. The control word is written through a simple write strobe and is always visible on a read-data port.

Top module: `oc_channel`

## Requirements
- R1: While reset is high and in the cycle after it falls, `pin_out`, `irq` and `ctrl_rdata` are all 0.
- R2: Control word layout: bits 2:0 are the mode, bit 3 is the timebase select, bit 13 is the idle-stop control and bit 4 is the fault status. Bit 4 cannot be written, and every other bit reads 0. A write of 16'hFFFF with no fault reads back 16'h200F.
- R3: Mode 1 loads the pin low and sets it high when the count equals the primary value. Mode 2 loads the pin high and clears it on that match.
- R4: Mode 3 loads the pin low and inverts it on every primary match.
- R5: With the timebase select at 0 the channel uses timer A's count and period strobe. With it at 1 it uses timer B's, and timer A has no effect.
- R6: Mode 4 loads the pin low. The pin rises on a primary match and falls on a secondary match. After that it stays low until the control word is written again.
- R7: Mode 5 behaves like mode 4 but keeps repeating the pulse.
- R8: Modes 6 and 7 are PWM. On each period strobe the secondary value is latched as the duty and the pin goes high if that value is nonzero. The pin goes low when the count equals the latched duty. A change in the secondary value between strobes has no effect.
- R9: In mode 7, a low `fault_n` drives the pin low one clock later and sets status bit 4. The pin stays low, and the status clears, at the first period strobe seen with `fault_n` high. In mode 6 the fault input is ignored, and the status is only ever set in mode 7.
- R10: With idle-stop at 1 and `idle_req` high, the pin holds and no strobe is produced (except for fault shutdown). With idle-stop at 0 the channel keeps running.
- R11: `irq` is a one-clock pulse for each clock with a match. In modes 1 to 3 this is a primary match. In modes 4 and 5 it is a primary or a secondary match. In modes 6 and 7 it is a period strobe.
- R12: Mode 0 forces the pin low and clears the pulse state. It produces no strobe and reacts to no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word write data |
| ctrl_rdata | output | 16 | Control word read data, including fault status |
| tmr_a_cnt | input | DW | Timer A count |
| tmr_a_prd | input | 1 | Timer A period strobe |
| tmr_b_cnt | input | DW | Timer B count |
| tmr_b_prd | input | 1 | Timer B period strobe |
| cmp_pri | input | DW | Primary compare value |
| cmp_sec | input | DW | Secondary compare value / PWM duty source |
| idle_req | input | 1 | Idle request |
| fault_n | input | 1 | Active-low fault input |
| pin_out | output | 1 | Output pin level |
| irq | output | 1 | One-clock compare event strobe |

## Verification
The bench builds the channel with DW set to 8. With this width, every compare value, duty and timer count it uses fits in small hand-chosen numbers, and each mode runs in a few dozen cycles. The bench drives the timer counts directly rather than letting them run. Because of this it can put a match, a period strobe, a fault edge and a control write on the same clock or on adjacent clocks. This gives it direct access to duty latching at the boundary, zero duty, the end of a single pulse, and fault recovery on the boundary clock.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_OFF  = 3'd0,
    OC_SET  = 3'd1,
    OC_CLR  = 3'd2,
    OC_TGL  = 3'd3,
    OC_ONE  = 3'd4,
    OC_RPT  = 3'd5,
    OC_PWM  = 3'd6,
    OC_PWMF = 3'd7
  } oc_mode_e;

  localparam int CW        = 16;
  localparam int ISTOP_BIT = 13;
  localparam int FLT_BIT   = 4;
  localparam int TSEL_BIT  = 3;
endpackage

// File: rtl/oc_ctrl_reg.sv
module oc_ctrl_reg
  import oc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          fault_n,
  input  logic          prd_run,
  output oc_mode_e      mode,
  output logic          tsel,
  output logic          istop,
  output logic          flt,
  output logic [CW-1:0] rdata
);
  oc_mode_e mode_q;
  logic     tsel_q, istop_q, flt_q;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[CW-1:ISTOP_BIT+1], wdata[ISTOP_BIT-1:FLT_BIT]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= OC_OFF;
      tsel_q  <= 1'b0;
      istop_q <= 1'b0;
      flt_q   <= 1'b0;
    end else if (we) begin
      mode_q  <= oc_mode_e'(wdata[2:0]);
      tsel_q  <= wdata[TSEL_BIT];
      istop_q <= wdata[ISTOP_BIT];
      flt_q   <= 1'b0;
    end else if (mode_q == OC_PWMF) begin
      if (!fault_n)
        flt_q <= 1'b1;
      else if (prd_run)
        flt_q <= 1'b0;
    end else begin
      flt_q <= 1'b0;
    end
  end

  assign mode  = mode_q;
  assign tsel  = tsel_q;
  assign istop = istop_q;
  assign flt   = flt_q;

  always_comb begin
    rdata            = '0;
    rdata[2:0]       = mode_q;
    rdata[TSEL_BIT]  = tsel_q;
    rdata[FLT_BIT]   = flt_q;
    rdata[ISTOP_BIT] = istop_q;
  end
endmodule

// File: rtl/oc_tbase_sel.sv
module oc_tbase_sel #(
  parameter int DW = 16
) (
  input  logic          tsel,
  input  logic [DW-1:0] cnt_a,
  input  logic          prd_a,
  input  logic [DW-1:0] cnt_b,
  input  logic          prd_b,
  output logic [DW-1:0] cnt,
  output logic          prd
);
  always_comb begin
    if (tsel) begin
      cnt = cnt_b;
      prd = prd_b;
    end else begin
      cnt = cnt_a;
      prd = prd_a;
    end
  end
endmodule

// File: rtl/oc_wave.sv
module oc_wave
  import oc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  oc_mode_e      mode,
  input  logic          load,
  input  oc_mode_e      new_mode,
  input  logic          run,
  input  logic [DW-1:0] cnt,
  input  logic          prd,
  input  logic [DW-1:0] pri,
  input  logic [DW-1:0] sec,
  input  logic          fault_n,
  input  logic          flt,
  output logic          pin,
  output logic          irq
);
  logic          pin_q, irq_q, done_q;
  logic [DW-1:0] duty_q;
  logic          hit_pri, hit_sec, hit_duty;

  assign hit_pri  = (cnt == pri);
  assign hit_sec  = (cnt == sec);
  assign hit_duty = (cnt == duty_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q  <= 1'b0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      duty_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (load) begin
        pin_q  <= (new_mode == OC_CLR);
        done_q <= 1'b0;
      end else if (mode == OC_PWMF && !fault_n) begin
        pin_q <= 1'b0;
      end else if (run) begin
        unique case (mode)
          OC_SET: if (hit_pri) begin pin_q <= 1'b1;   irq_q <= 1'b1; end
          OC_CLR: if (hit_pri) begin pin_q <= 1'b0;   irq_q <= 1'b1; end
          OC_TGL: if (hit_pri) begin pin_q <= ~pin_q; irq_q <= 1'b1; end
          OC_ONE, OC_RPT: begin
            irq_q <= hit_pri | hit_sec;
            if (!pin_q && !done_q && hit_pri)
              pin_q <= 1'b1;
            else if (pin_q && hit_sec) begin
              pin_q  <= 1'b0;
              done_q <= (mode == OC_ONE);
            end
          end
          OC_PWM, OC_PWMF: begin
            if (prd) begin
              duty_q <= sec;
              pin_q  <= (sec != '0);
              irq_q  <= 1'b1;
            end else if (flt || hit_duty) begin
              pin_q <= 1'b0;
            end
          end
          default: pin_q <= 1'b0;
        endcase
      end
    end
  end

  assign pin = pin_q;
  assign irq = irq_q;
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_we,
  input  logic [15:0]   ctrl_wdata,
  output logic [15:0]   ctrl_rdata,
  input  logic [DW-1:0] tmr_a_cnt,
  input  logic          tmr_a_prd,
  input  logic [DW-1:0] tmr_b_cnt,
  input  logic          tmr_b_prd,
  input  logic [DW-1:0] cmp_pri,
  input  logic [DW-1:0] cmp_sec,
  input  logic          idle_req,
  input  logic          fault_n,
  output logic          pin_out,
  output logic          irq
);
  oc_mode_e      mode;
  logic          tsel, istop, flt, run, prd;
  logic [DW-1:0] cnt;

  assign run = !(istop && idle_req);

  oc_ctrl_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .we      (ctrl_we),
    .wdata   (ctrl_wdata),
    .fault_n (fault_n),
    .prd_run (prd & run),
    .mode    (mode),
    .tsel    (tsel),
    .istop   (istop),
    .flt     (flt),
    .rdata   (ctrl_rdata)
  );

  oc_tbase_sel #(.DW(DW)) u_tb (
    .tsel  (tsel),
    .cnt_a (tmr_a_cnt),
    .prd_a (tmr_a_prd),
    .cnt_b (tmr_b_cnt),
    .prd_b (tmr_b_prd),
    .cnt   (cnt),
    .prd   (prd)
  );

  oc_wave #(.DW(DW)) u_wave (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .load     (ctrl_we),
    .new_mode (oc_mode_e'(ctrl_wdata[2:0])),
    .run      (run),
    .cnt      (cnt),
    .prd      (prd),
    .pri      (cmp_pri),
    .sec      (cmp_sec),
    .fault_n  (fault_n),
    .flt      (flt),
    .pin      (pin_out),
    .irq      (irq)
  );
endmodule

// File: rtl/oc_channel_chk.sv
module oc_channel_chk (
  input logic        clk,
  input logic        rst,
  input logic        ctrl_we,
  input logic [15:0] ctrl_wdata,
  input logic [15:0] ctrl_rdata,
  input logic        idle_req,
  input logic        fault_n,
  input logic        pin_out,
  input logic        irq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pin_out && !irq && ctrl_rdata == 16'h0));

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> (ctrl_rdata[3:0] == $past(ctrl_wdata[3:0])
                 && ctrl_rdata[13] == $past(ctrl_wdata[13])
                 && !ctrl_rdata[4]));

  assert_fault_shutdown_R9: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata[2:0] == 3'd7 && !fault_n && !ctrl_we) |=> (!pin_out && ctrl_rdata[4]));

  assert_fault_only_pwmf_R9: assert property (@(posedge clk) disable iff (rst)
    ctrl_rdata[4] |-> ctrl_rdata[2:0] == 3'd7);

  assert_idle_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata[13] && idle_req && ctrl_rdata[2:0] != 3'd7 && !ctrl_we)
      |=> ($stable(pin_out) && !irq));

  assert_off_low_R12: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_wdata[2:0] == 3'd0) |=> !pin_out);

  assert_off_silent_R12: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rdata[2:0] == 3'd0 && !ctrl_we) |=> (!irq && !pin_out));
endmodule

bind oc_channel oc_channel_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .ctrl_rdata (ctrl_rdata),
  .idle_req   (idle_req),
  .fault_n    (fault_n),
  .pin_out    (pin_out),
  .irq        (irq)
);

// File: tb/tb_oc_channel.sv
module tb_oc_channel;
  localparam int DW = 8;
  localparam logic [DW-1:0] PRI = 8'd10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic [15:0]   wd = '0;
  logic [15:0]   rd;
  logic [DW-1:0] ca = '0, cb = '0, sec = 8'd20;
  logic          pa = 1'b0, pb = 1'b0, idle = 1'b0, fn = 1'b1;
  logic          pin, irq;
  int            checks = 0, failures = 0, cycles = 0;
  logic          ended = 1'b0;

  always #2 clk = ~clk;

  oc_channel #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .ctrl_we(we), .ctrl_wdata(wd), .ctrl_rdata(rd),
    .tmr_a_cnt(ca), .tmr_a_prd(pa), .tmr_b_cnt(cb), .tmr_b_prd(pb),
    .cmp_pri(PRI), .cmp_sec(sec), .idle_req(idle), .fault_n(fn),
    .pin_out(pin), .irq(irq)
  );

  typedef struct packed {
    logic          we;
    logic [15:0]   wd;
    logic [DW-1:0] ca;
    logic          pa;
    logic [DW-1:0] cb;
    logic          pb;
    logic [DW-1:0] sec;
    logic          fn;
    logic          pin;
    logic          irq;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0001, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R3 mode 1 load
    '{1'b0, 16'h0000, 8'd5,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R3 set on match
    '{1'b0, 16'h0000, 8'd11, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b0}, // R11 single clock
    '{1'b1, 16'h0002, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b0}, // R3 mode 2 loads high
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1}, // R3 clear on match
    '{1'b1, 16'h0003, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R4
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R4 toggle
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1}, // R4 R11 back-to-back
    '{1'b0, 16'h0000, 8'd3,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0},
    '{1'b1, 16'h000B, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R5 select B
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R5 A ignored
    '{1'b0, 16'h0000, 8'd0,  1'b0, 8'd10, 1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R5 B matches
    '{1'b1, 16'h0004, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R6
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R6 rise
    '{1'b0, 16'h0000, 8'd15, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1}, // R6 fall
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1}, // R6 stays low
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'h0005, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R7
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1},
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'h0000, 8'd10, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R7 repeats
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'h0006, 8'd0,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R8
    '{1'b0, 16'h0000, 8'd0,  1'b1, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1}, // R8 R11 period
    '{1'b0, 16'h0000, 8'd5,  1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0}, // R8 duty end
    '{1'b0, 16'h0000, 8'd25, 1'b0, 8'd0,  1'b0, 8'd20, 1'b1, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 8'd0,  1'b1, 8'd0,  1'b0, 8'd20, 1'b1, 1'b1, 1'b1},
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd30, 1'b1, 1'b0, 1'b0}, // R8 latch holds 20
    '{1'b0, 16'h0000, 8'd0,  1'b1, 8'd0,  1'b0, 8'd30, 1'b1, 1'b1, 1'b1},
    '{1'b0, 16'h0000, 8'd20, 1'b0, 8'd0,  1'b0, 8'd30, 1'b1, 1'b1, 1'b0}, // R8 new duty 30
    '{1'b0, 16'h0000, 8'd30, 1'b0, 8'd0,  1'b0, 8'd30, 1'b1, 1'b0, 1'b0},
    '{1'b0, 16'h0000, 8'd0,  1'b1, 8'd0,  1'b0, 8'd30, 1'b0, 1'b1, 1'b1}, // R9 fault ignored mode 6
    '{1'b0, 16'h0000, 8'd5,  1'b0, 8'd0,  1'b0, 8'd30, 1'b0, 1'b1, 1'b0},
    '{1'b0, 16'h0000, 8'd0,  1'b1, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b1}, // R8 zero duty
    '{1'b0, 16'h0000, 8'd5,  1'b0, 8'd0,  1'b0, 8'd0,  1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] d, input logic [DW-1:0] a,
                      input logic p, input logic [DW-1:0] s, input logic i, input logic f);
    we = w; wd = d; ca = a; pa = p; sec = s; idle = i; fn = f;
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input string req, input logic ep, input logic ei);
    chk(pin === ep, {req, " pin"}, {15'b0, pin}, {15'b0, ep});
    chk(irq === ei, {req, " irq"}, {15'b0, irq}, {15'b0, ei});
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(pin === 1'b0 && irq === 1'b0, "R1 outputs in reset", {14'b0, pin, irq}, 16'h0);
    chk(rd === 16'h0, "R1 rdata in reset", rd, 16'h0);
    rst = 1'b0;
    @(posedge clk); #1;
    chk(rd === 16'h0 && !pin && !irq, "R1 after release", rd, 16'h0);

    for (int k = 0; k < NV; k++) begin
      we = VEC[k].we; wd = VEC[k].wd; ca = VEC[k].ca; pa = VEC[k].pa;
      cb = VEC[k].cb; pb = VEC[k].pb; sec = VEC[k].sec; fn = VEC[k].fn; idle = 1'b0;
      @(posedge clk); #1;
      if (pin !== VEC[k].pin || irq !== VEC[k].irq) begin
        failures++;
        $display("FAIL vector %0d (R3-R9/R11 table) actual pin=%b irq=%b expected pin=%b irq=%b",
                 k, pin, irq, VEC[k].pin, VEC[k].irq);
      end
      checks++;
    end
    cb = '0; pb = 1'b0;

    // R2 layout and read-only fault bit
    step(1'b1, 16'hFFFF, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    chk(rd === 16'h200F, "R2 readback", rd, 16'h200F);

    // R9 fault in mode 7
    step(1'b1, 16'h0007, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd0, 1'b1, 8'd20, 1'b0, 1'b1);
    chk_out("R9 pwm start", 1'b1, 1'b1);
    step(1'b0, 16'h0000, 8'd5, 1'b0, 8'd20, 1'b0, 1'b0);
    chk_out("R9 shutdown", 1'b0, 1'b0);
    chk(rd === 16'h0017, "R9 status set", rd, 16'h0017);
    step(1'b0, 16'h0000, 8'd6, 1'b0, 8'd20, 1'b0, 1'b1);
    chk(pin === 1'b0 && rd === 16'h0017, "R9 held until period", rd, 16'h0017);
    step(1'b0, 16'h0000, 8'd0, 1'b1, 8'd20, 1'b0, 1'b1);
    chk_out("R9 resume", 1'b1, 1'b1);
    chk(rd === 16'h0007, "R9 status cleared", rd, 16'h0007);

    // R10 idle stop freezes, idle run continues
    step(1'b1, 16'h2001, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd10, 1'b0, 8'd20, 1'b1, 1'b1);
    chk_out("R10 frozen", 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'd10, 1'b0, 8'd20, 1'b0, 1'b1);
    chk_out("R10 thawed", 1'b1, 1'b1);
    step(1'b1, 16'h0003, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd10, 1'b0, 8'd20, 1'b1, 1'b1);
    chk_out("R10 idle keeps running", 1'b1, 1'b1);

    // R12 mode 0 forces low and ignores matches
    step(1'b1, 16'h0000, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    chk_out("R12 forced low", 1'b0, 1'b0);
    step(1'b0, 16'h0000, 8'd10, 1'b1, 8'd10, 1'b0, 1'b1);
    chk_out("R12 match ignored", 1'b0, 1'b0);

    // R6 rewrite re-arms single pulse
    step(1'b1, 16'h0004, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd10, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd20, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b1, 16'h0004, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    step(1'b0, 16'h0000, 8'd10, 1'b0, 8'd20, 1'b0, 1'b1);
    chk_out("R6 re-armed", 1'b1, 1'b1);

    // R1 reset mid-run
    rst = 1'b1;
    step(1'b0, 16'h0000, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);
    chk(rd === 16'h0 && !pin && !irq, "R1 reset mid-run", rd, 16'h0);
    rst = 1'b0;
    step(1'b0, 16'h0000, 8'd0, 1'b0, 8'd20, 1'b0, 1'b1);

    finish_run();
  end
endmodule